// File: doc/BRIEF.md
# DRAM Write Burst Sequencer

This block is the controller-side engine that performs one write burst to a graphics DRAM. A client presents a request carrying a bank, a column, an auto-precharge flag and eight data words through a valid/ready handshake. The sequencer then drives the command and address pins over two consecutive clocks. It produces the write strobe as a preamble of programmable length, four toggling cycles that carry the eight words (two per clock, one on each strobe edge) and a driven-high postamble. It returns the data lines to all-ones afterwards.

Optional data inversion lowers the number of zeros on the bus. When inversion is enabled, each word with more zero bits than one bits is sent complemented, and its flag pin is raised so that the memory stores the true value. Write latency, preamble length and the inversion enable are configuration inputs. They are captured when a request is accepted, so one burst always runs with one consistent setting. The block never cuts a burst short. It holds off the next request until the postamble is over and the minimum command spacing has passed.

Top module: `wr_burst_seq`

## Requirements
- R1: When a request is accepted (`req_valid` and `req_ready` high at a rising edge), the next cycle shows `cmd_o` = 1 (write), `ba_o` = bank and `addr_o[4:0]` = column bits [9:5]. In every other cycle `cmd_o` = 0 (no-op) and `ba_o` = 0.
- R2: In the write cycle, `addr_o[8]` equals the auto-precharge flag. In the cycle after it, `addr_o[4:0]` = column bits [4:0] and all other address bits are 0. In all other cycles `addr_o` = 0.
- R3: `stb_o` codes are 0 = not driven, 1 = driven low (preamble), 2 = toggling with data, 3 = driven high (postamble). Counting the write cycle as cycle 0, the preamble occupies cycles WL to WL+P-1. WL is `cfg_wl` and P is `cfg_wpre`, with 0 treated as 1.
- R4: Cycles WL+P to WL+P+3 show `stb_o` = 2. Data cycle j carries word 2j on `dq_rise_o` and word 2j+1 on `dq_fall_o`. Word i is `req_data[32i+31:32i]`.
- R5: Exactly one postamble cycle (`stb_o` = 3) follows the last data cycle.
- R6: Outside data cycles, `dq_rise_o` and `dq_fall_o` are all ones and both flags are 0.
- R7: With inversion enabled, a word with fewer than DW/2 one bits goes out complemented with its flag at 1. A word with DW/2 or more one bits goes out unchanged with its flag at 0.
- R8: With inversion disabled, every word goes out unchanged and both flags stay 0.
- R9: The next write cycle comes exactly max(WL+P+5, 4) cycles after the previous one when a request is held waiting. `req_ready` is low in between.
- R10: A change of `cfg_wl`, `cfg_wpre` or `cfg_inv_en` after acceptance has no effect on the burst in progress.
- R11: During reset `req_ready` = 1, `cmd_o` = 0, `stb_o` = 0 and the data lines are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_bank | input | BA_W | Target bank |
| req_col | input | COL_W | Starting column |
| req_ap | input | 1 | Auto-precharge after the burst |
| req_data | input | 8*DW | Eight data words, word i in bits [DW*i+DW-1:DW*i] |
| cfg_wl | input | WL_W | Write latency in cycles |
| cfg_wpre | input | PRE_W | Preamble cycles (0 treated as 1) |
| cfg_inv_en | input | 1 | Data inversion enable |
| cmd_o | output | 2 | Command code: 0 no-op, 1 write |
| ba_o | output | BA_W | Bank address pins |
| addr_o | output | ADDR_W | Address pins |
| stb_o | output | 2 | Write strobe state code |
| dq_rise_o | output | DW | Word on the rising strobe edge |
| dq_fall_o | output | DW | Word on the falling strobe edge |
| dbi_rise_o | output | 1 | Inversion flag for the rising word |
| dbi_fall_o | output | 1 | Inversion flag for the falling word |

## Verification
A wrong cycle count inside the sequencer shows up at once on the strobe code. A preamble, data or postamble phase that starts one cycle early or late mismatches in that same cycle, and a wrong spacing count moves `req_ready` and the next write cycle. A wrong word index or inversion decision corrupts `dq_rise_o`/`dq_fall_o` in the very data cycle it affects. A bad configuration latch changes the phase positions of the current burst. Comparing every output against a behavioural model on every clock therefore catches each fault within one cycle of it becoming visible.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_WRITE = 2'd1
  } wbs_cmd_e;

  typedef enum logic [1:0] {
    STB_OFF  = 2'd0,
    STB_LOW  = 2'd1,
    STB_TOG  = 2'd2,
    STB_HIGH = 2'd3
  } wbs_stb_e;

  // A zero preamble setting still yields one preamble cycle.
  function automatic int unsigned eff_preamble(input int unsigned p);
    return (p == 0) ? 1 : p;
  endfunction

  // Cycles from one write command to the earliest next one.
  function automatic int unsigned burst_gap(input int unsigned data_start,
                                            input int unsigned beats,
                                            input int unsigned min_space);
    int unsigned span;
    span = data_start + beats + 1;
    return (span > min_space) ? span : min_space;
  endfunction

endpackage

// File: rtl/wbs_timer.sv
module wbs_timer
  import wbs_pkg::*;
#(
  parameter int unsigned WL_W      = 4,
  parameter int unsigned PRE_W     = 2,
  parameter int unsigned BEATS     = 4,
  parameter int unsigned MIN_SPACE = 4,
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned BEAT_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [WL_W-1:0]   wl,
  input  logic [PRE_W-1:0]  pre,
  output logic              ready,
  output logic              ph_cmd,
  output logic              ph_addr2,
  output logic              ph_pre,
  output logic              ph_data,
  output logic              ph_post,
  output logic [BEAT_W-1:0] beat
);

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] wl_c;
  logic [CNT_W-1:0] data_start;
  logic [CNT_W-1:0] post_at;
  logic [CNT_W-1:0] gap_m1;

  always_comb begin
    wl_c       = CNT_W'(wl);
    data_start = wl_c + CNT_W'(eff_preamble(32'(pre)));
    post_at    = data_start + CNT_W'(BEATS);
    gap_m1     = CNT_W'(burst_gap(32'(data_start), BEATS, MIN_SPACE) - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (accept) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (cnt == gap_m1) active <= 1'b0;
      else               cnt    <= cnt + 1'b1;
    end
  end

  assign ready    = !active || (cnt == gap_m1);
  assign ph_cmd   = active && (cnt == '0);
  assign ph_addr2 = active && (cnt == CNT_W'(1));
  assign ph_pre   = active && (cnt >= wl_c) && (cnt < data_start);
  assign ph_data  = active && (cnt >= data_start) && (cnt < post_at);
  assign ph_post  = active && (cnt == post_at);
  assign beat     = BEAT_W'(cnt - data_start);

endmodule

// File: rtl/wbs_cmdaddr.sv
module wbs_cmdaddr
  import wbs_pkg::*;
#(
  parameter int unsigned BA_W   = 4,
  parameter int unsigned COL_W  = 10,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned AP_BIT = 8
) (
  input  logic              ph_cmd,
  input  logic              ph_addr2,
  input  logic [BA_W-1:0]   bank,
  input  logic [COL_W-1:0]  col,
  input  logic              ap,
  output wbs_cmd_e          cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);

  localparam int unsigned COL_LO_W = COL_W / 2;
  localparam int unsigned COL_HI_W = COL_W - COL_LO_W;

  always_comb begin
    cmd  = CMD_NOP;
    ba   = '0;
    addr = '0;
    if (ph_cmd) begin
      cmd                  = CMD_WRITE;
      ba                   = bank;
      addr[COL_HI_W-1:0]   = col[COL_W-1:COL_LO_W];
      addr[AP_BIT]         = ap;
    end else if (ph_addr2) begin
      addr[COL_LO_W-1:0]   = col[COL_LO_W-1:0];
    end
  end

endmodule

// File: rtl/wbs_dbi_lane.sv
module wbs_dbi_lane #(
  parameter int unsigned DW = 32
) (
  input  logic          active,
  input  logic          inv_en,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] dq,
  output logic          flag
);

  function automatic int unsigned zero_count(input logic [DW-1:0] w);
    int unsigned n;
    n = 0;
    for (int i = 0; i < DW; i++) if (!w[i]) n++;
    return n;
  endfunction

  logic invert;

  assign invert = inv_en && (zero_count(word) > DW / 2);
  assign dq     = !active ? '1 : (invert ? ~word : word);
  assign flag   = active && invert;

endmodule

// File: rtl/wr_burst_seq.sv
module wr_burst_seq
  import wbs_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter int unsigned BA_W      = 4,
  parameter int unsigned COL_W     = 10,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned AP_BIT    = 8,
  parameter int unsigned WL_W      = 4,
  parameter int unsigned PRE_W     = 2,
  parameter int unsigned MIN_SPACE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_ap,
  input  logic [8*DW-1:0]   req_data,
  input  logic [WL_W-1:0]   cfg_wl,
  input  logic [PRE_W-1:0]  cfg_wpre,
  input  logic              cfg_inv_en,
  output logic [1:0]        cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        stb_o,
  output logic [DW-1:0]     dq_rise_o,
  output logic [DW-1:0]     dq_fall_o,
  output logic              dbi_rise_o,
  output logic              dbi_fall_o
);

  localparam int unsigned BL     = 8;
  localparam int unsigned BEATS  = BL / 2;
  localparam int unsigned BEAT_W = $clog2(BEATS);
  localparam int unsigned CNT_W  = $clog2((2 ** WL_W) + (2 ** PRE_W) + BEATS + MIN_SPACE + 2);

  // Latched request and configuration
  logic [BA_W-1:0]  bank_q;
  logic [COL_W-1:0] col_q;
  logic             ap_q;
  logic [WL_W-1:0]  wl_q;
  logic [PRE_W-1:0] pre_q;
  logic             inv_q;
  logic [DW-1:0]    words_q [BL];

  // Named internal events
  logic              accept;
  logic              ph_cmd;
  logic              ph_addr2;
  logic              ph_pre;
  logic              ph_data;
  logic              ph_post;
  logic              beat_last;
  logic [BEAT_W-1:0] beat;

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      col_q  <= '0;
      ap_q   <= 1'b0;
      wl_q   <= '0;
      pre_q  <= '0;
      inv_q  <= 1'b0;
      for (int i = 0; i < BL; i++) words_q[i] <= '0;
    end else if (accept) begin
      bank_q <= req_bank;
      col_q  <= req_col;
      ap_q   <= req_ap;
      wl_q   <= cfg_wl;
      pre_q  <= cfg_wpre;
      inv_q  <= cfg_inv_en;
      for (int i = 0; i < BL; i++) words_q[i] <= req_data[i*DW +: DW];
    end
  end

  wbs_timer #(
    .WL_W(WL_W), .PRE_W(PRE_W), .BEATS(BEATS), .MIN_SPACE(MIN_SPACE),
    .CNT_W(CNT_W), .BEAT_W(BEAT_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .accept(accept), .wl(wl_q), .pre(pre_q),
    .ready(req_ready), .ph_cmd(ph_cmd), .ph_addr2(ph_addr2), .ph_pre(ph_pre),
    .ph_data(ph_data), .ph_post(ph_post), .beat(beat)
  );

  assign beat_last = ph_data && (beat == BEAT_W'(BEATS - 1));

  wbs_cmd_e cmd;

  wbs_cmdaddr #(
    .BA_W(BA_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
  ) u_cmdaddr (
    .ph_cmd(ph_cmd), .ph_addr2(ph_addr2), .bank(bank_q), .col(col_q),
    .ap(ap_q), .cmd(cmd), .ba(ba_o), .addr(addr_o)
  );

  assign cmd_o = cmd;

  wbs_stb_e stb;

  always_comb begin
    if (ph_data)      stb = STB_TOG;
    else if (ph_post) stb = STB_HIGH;
    else if (ph_pre)  stb = STB_LOW;
    else              stb = STB_OFF;
  end

  assign stb_o = stb;

  // Two lanes: lane 0 for the rising edge word, lane 1 for the falling one
  logic [DW-1:0] lane_dq   [2];
  logic          lane_flag [2];

  for (genvar e = 0; e < 2; e++) begin : g_lane
    logic [BEAT_W:0] idx;
    assign idx = {beat, 1'b0} + (BEAT_W + 1)'(e);
    wbs_dbi_lane #(.DW(DW)) u_lane (
      .active(ph_data), .inv_en(inv_q), .word(words_q[idx]),
      .dq(lane_dq[e]), .flag(lane_flag[e])
    );
  end

  assign dq_rise_o  = lane_dq[0];
  assign dq_fall_o  = lane_dq[1];
  assign dbi_rise_o = lane_flag[0];
  assign dbi_fall_o = lane_flag[1];

endmodule

// File: rtl/wbs_checker.sv
module wbs_checker #(
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned AP_BIT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        stb,
  input logic [DW-1:0]     dq_rise,
  input logic [DW-1:0]     dq_fall,
  input logic              dbi_rise,
  input logic              dbi_fall,
  input logic              ph_pre,
  input logic              ph_data,
  input logic              ph_post,
  input logic              beat_last
);

  a_r1_cmd_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd == 2'd1));

  a_r9_busy_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'd1) |-> !req_ready);

  a_r9_busy_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'd1) |=> !req_ready);

  a_r2_ap_only_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != 2'd1) |-> !addr[AP_BIT]);

  a_r3_pre_leads_data: assert property (@(posedge clk) disable iff (!rst_n)
    (stb == 2'd1) |=> (stb == 2'd1 || stb == 2'd2));

  a_r5_post_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |=> (stb == 2'd3));

  a_r5_post_single: assert property (@(posedge clk) disable iff (!rst_n)
    (stb == 2'd3) |=> (stb != 2'd3 && stb != 2'd2));

  a_r6_lines_high: assert property (@(posedge clk) disable iff (!rst_n)
    (stb != 2'd2) |-> (dq_rise == '1 && dq_fall == '1 && !dbi_rise && !dbi_fall));

  a_r7_rise_flag_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    dbi_rise |-> ($countones(dq_rise) > DW / 2));

  a_r7_fall_flag_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    dbi_fall |-> ($countones(dq_fall) > DW / 2));

  a_r4_phases_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ph_pre, ph_data, ph_post}));

endmodule

bind wr_burst_seq wbs_checker #(
  .DW(DW), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
) u_wbs_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cmd(cmd_o), .addr(addr_o), .stb(stb_o), .dq_rise(dq_rise_o),
  .dq_fall(dq_fall_o), .dbi_rise(dbi_rise_o), .dbi_fall(dbi_fall_o),
  .ph_pre(ph_pre), .ph_data(ph_data), .ph_post(ph_post), .beat_last(beat_last)
);

// File: tb/test_wr_burst_seq.sv
`timescale 1ns/1ps
module test_wr_burst_seq;

  localparam int DW     = 32;
  localparam int BA_W   = 4;
  localparam int COL_W  = 10;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [BA_W-1:0]   req_bank = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic              req_ap = 1'b0;
  logic [8*DW-1:0]   req_data = '0;
  logic [3:0]        cfg_wl = 4'd0;
  logic [1:0]        cfg_wpre = 2'd0;
  logic              cfg_inv_en = 1'b0;
  logic [1:0]        cmd_o;
  logic [BA_W-1:0]   ba_o;
  logic [ADDR_W-1:0] addr_o;
  logic [1:0]        stb_o;
  logic [DW-1:0]     dq_rise_o, dq_fall_o;
  logic              dbi_rise_o, dbi_fall_o;

  wr_burst_seq i_wr_burst_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_col(req_col), .req_ap(req_ap), .req_data(req_data),
    .cfg_wl(cfg_wl), .cfg_wpre(cfg_wpre), .cfg_inv_en(cfg_inv_en),
    .cmd_o(cmd_o), .ba_o(ba_o), .addr_o(addr_o), .stb_o(stb_o),
    .dq_rise_o(dq_rise_o), .dq_fall_o(dq_fall_o),
    .dbi_rise_o(dbi_rise_o), .dbi_fall_o(dbi_fall_o)
  );

  always #2 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  // Behavioural reference model: kk = cycles since the write command, -1 idle
  int kk = -1;
  int m_wl, m_p, m_gap, m_bank, m_col;
  bit m_inv, m_ap;
  bit cfg_moved = 1'b0;
  logic [DW-1:0] m_words[$];

  function automatic bit exp_ready();
    return (kk < 0) || (kk == m_gap - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) kk = -1;
    else if (req_valid && exp_ready()) begin
      m_wl   = int'(cfg_wl);
      m_p    = (cfg_wpre == 2'd0) ? 1 : int'(cfg_wpre);
      m_inv  = cfg_inv_en;
      m_bank = int'(req_bank);
      m_col  = int'(req_col);
      m_ap   = req_ap;
      m_gap  = (m_wl + m_p + 5 > 4) ? m_wl + m_p + 5 : 4;
      m_words.delete();
      for (int i = 0; i < 8; i++) m_words.push_back(req_data[i*DW +: DW]);
      cfg_moved = 1'b0;
      kk = 0;
    end else if (kk >= 0) begin
      if (kk == m_gap - 1) kk = -1;
      else kk++;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [32:0] enc_word(input logic [DW-1:0] w, input bit inv);
    if (inv && ($countones(w) < DW / 2)) return {1'b1, ~w};
    return {1'b0, w};
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      int ds;
      int e_cmd, e_ba, e_addr, e_stb;
      logic [32:0] e_r, e_f;
      string sfx, t_stb, t_dq;
      sfx   = cfg_moved ? " R10" : "";
      ds    = m_wl + m_p;
      e_cmd = 0; e_ba = 0; e_addr = 0; e_stb = 0;
      e_r   = {1'b0, {DW{1'b1}}};
      e_f   = {1'b0, {DW{1'b1}}};
      t_stb = "R6"; t_dq = "R6";
      if (!rst_n) begin
        t_stb = "R11"; t_dq = "R11";
      end else if (kk >= 0) begin
        if (kk == 0) begin
          e_cmd = 1; e_ba = m_bank;
          e_addr = (m_col >> 5) | (int'(m_ap) << 8);
        end else if (kk == 1) begin
          e_addr = m_col & 31;
        end
        if (kk >= ds && kk < ds + 4) begin
          e_stb = 2; t_stb = "R4";
          e_r = enc_word(m_words[2*(kk-ds)], m_inv);
          e_f = enc_word(m_words[2*(kk-ds)+1], m_inv);
          t_dq = m_inv ? "R7 R4" : "R8 R4";
        end else if (kk == ds + 4) begin
          e_stb = 3; t_stb = "R5";
        end else if (kk >= m_wl && kk < ds) begin
          e_stb = 1; t_stb = "R3";
        end
      end
      chk({"R9 ready", sfx}, 64'(req_ready), 64'(exp_ready()));
      chk({"R1 cmd/bank", sfx}, {cmd_o, 28'(ba_o)}, {2'(e_cmd), 28'(e_ba)});
      chk({"R2 addr", sfx}, 64'(addr_o), 64'(e_addr));
      chk({t_stb, " strobe", sfx}, 64'(stb_o), 64'(e_stb));
      chk({t_dq, " rise", sfx}, 64'({dbi_rise_o, dq_rise_o}), 64'(e_r));
      chk({t_dq, " fall", sfx}, 64'({dbi_fall_o, dq_fall_o}), 64'(e_f));
    end
  end

  task automatic send(input int bank, input int col, input bit ap, input int wl,
                      input int pre, input bit inv, input logic [DW-1:0] w[8]);
    @(negedge clk); #1;
    req_valid  = 1'b1;
    req_bank   = BA_W'(bank);
    req_col    = COL_W'(col);
    req_ap     = ap;
    cfg_wl     = 4'(wl);
    cfg_wpre   = 2'(pre);
    cfg_inv_en = inv;
    for (int i = 0; i < 8; i++) req_data[i*DW +: DW] = w[i];
    while (!req_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk); #1;
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [DW-1:0] w[8];
    repeat (3) @(negedge clk);   // R11 reset state checked on these cycles
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R3 R4 R8: plain burst, latency 3, one preamble cycle
    for (int i = 0; i < 8; i++) w[i] = (32'h1111_1111 * (i + 1)) ^ 32'hA500_0000;
    send(3, 10'h2A5, 1'b0, 3, 1, 1'b0, w);

    // R7 boundaries, held back-to-back (R9)
    w = '{32'h0000_0000, 32'h0000_000F, 32'h7FFF_0000, 32'hFFFF_0000,
          32'hFFFF_FFFF, 32'h0001_0001, 32'hF0F0_F0F0, 32'h8000_0001};
    send(9, 10'h3FF, 1'b1, 5, 2, 1'b1, w);

    // Latency 0 with three preamble cycles, auto-precharge set
    for (int i = 0; i < 8; i++) w[i] = ~(32'h0101_0101 << i);
    send(15, 10'h000, 1'b1, 0, 3, 1'b1, w);

    // R10: configuration moves while the burst runs
    @(negedge clk); #1;
    req_valid  = 1'b0;
    cfg_wl     = 4'd9;
    cfg_wpre   = 2'd2;
    cfg_inv_en = 1'b0;
    cfg_moved  = 1'b1;
    repeat (20) @(negedge clk);

    // R3 zero preamble setting, R8 zero-heavy data without inversion
    for (int i = 0; i < 8; i++) w[i] = 32'h0000_0001 << (3 * i);
    send(2, 10'h155, 1'b0, 2, 0, 1'b0, w);
    @(negedge clk); #1;
    req_valid  = 1'b0;
    cfg_inv_en = 1'b1;
    cfg_wl     = 4'd1;
    cfg_moved  = 1'b1;
    repeat (15) @(negedge clk);

    // Largest latency and preamble, then the shortest burst back-to-back
    for (int i = 0; i < 8; i++) w[i] = 32'h00FF_0000 >> i;
    send(6, 10'h2C3, 1'b1, 15, 3, 1'b1, w);
    for (int i = 0; i < 8; i++) w[i] = 32'hDEAD_BEEF + 32'(i * 32'h1357_9BDF);
    send(1, 10'h01F, 1'b0, 1, 1, 1'b1, w);
    idle(40);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule